// File: doc/BRIEF.md
# Processor Bus Chip-Select and Port-Strobe Decoder

This block sits beside a 16-bit processor bus that carries a 20-bit byte address. It watches the address, the active-low high-byte enable, the memory/IO status line and the active-low read and write strobes. From them it forms active-low chip selects for a configurable set of memory regions and active-low enables for the even and odd byte lanes. It also forms gated select pulses for a small set of I/O ports. The path from input to output is purely combinational, so the selects follow the bus within the same cycle.

Each memory region has a base address and a decode style set by parameters. A fully decoded region compares every address bit above the bank-chip address lines and the lane bit. It answers to exactly one 16 KiB window. A partially decoded region compares only a few top address bits. It therefore answers at every alias address that differs in the ignored bits. When regions overlap, the lower-numbered region takes the cycle. I/O ports are matched on the low 16 address bits. An input port gets a read-enable pulse and an output port gets a latch strobe.

The default configuration has three regions. Region 0 is fully decoded at 0xFC000–0xFFFFF. Region 1 is fully decoded at 0x04000–0x07FFF. Region 2 is partially decoded on A19 = 0. There are four ports: input ports at 0x0040 and 0x1F00, and output ports at 0x0042 and 0x1F02.

Top module: `sysbus_select`

## Requirements
- R1: A fully decoded region drives its chip select low only when address bits 19..14 equal the region base bits 19..14. By default region 0 is selected for 0xFC000 and 0xFFFFF, and is not selected for 0xFBFFF.
- R2: A partially decoded region compares only its top address bits. By default region 2 needs bit 19 = 0, and bits 18..14 have no effect, so 0x00000, 0x3C123 and 0x7C000 all select it. 0x80000 does not select it.
- R3: When more than one region matches, only the lowest-numbered matching region drives its chip select low. By default 0x04000 selects region 1 and not region 2. At most one chip select is low at any time.
- R4: Byte-lane enables are active low and are driven only while some region chip select is low. The even enable is low when A0 = 0 and the odd enable is low when the high-byte enable is 0. A0 = 0 with the high-byte enable at 0 drives both low. A0 = 1 with the high-byte enable at 1 drives neither.
- R5: With the memory/IO line at 0 (an I/O cycle), every chip select and both lane enables stay high.
- R6: In an I/O cycle a port matches when address bits 15..0 equal its 16-bit port address. Bits 19..16 are ignored. Nothing matches in a memory cycle (memory/IO line at 1).
- R7: An input port's read select goes low only while the read strobe is low in a matching I/O cycle. A write strobe alone never drives it.
- R8: An output port's write select goes low only while the write strobe is low in a matching I/O cycle. A read strobe alone never drives it.
- R9: When both read and write strobes are high, every output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | ADDR_W (20) | Byte address; bit 0 selects the even lane |
| bhe_n | input | 1 | High-byte (odd lane) enable, active low |
| m_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_cs_n | output | NREG (3) | Region chip selects, active low, bit i = region i |
| even_en_n | output | 1 | Even byte-lane enable, active low |
| odd_en_n | output | 1 | Odd byte-lane enable, active low |
| io_rd_n | output | NPORT (4) | Read-enable per port (input ports only), active low |
| io_wr_n | output | NPORT (4) | Latch strobe per port (output ports only), active low |

## Verification
The bench probes the edges of the full windows, such as 0xFBFFF against 0xFC000. A decoder that compares one bit too few would select the address just below the window. Alias addresses of the partial region are swept, which catches a decoder that wrongly compares an ignored bit. The overlap at 0x04000 catches a priority that is inverted or missing, since such a design would drive two selects or the wrong one. I/O addresses with non-zero bits 19..16 and with the wrong strobe are also swept. These catch port decoders that look at the high nibble, that pulse a port on the opposite strobe, or that leak memory selects into I/O cycles.

// File: rtl/busdec_pkg.sv
`timescale 1ns/1ps
package busdec_pkg;

    // Bus cycle kind, active-high after decoding the strobes and status line
    typedef struct packed {
        logic mem;
        logic io;
        logic rd;
        logic wr;
    } cyc_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_EVEN  = 2'b01,
        ACC_ODD   = 2'b10,
        ACC_WORD  = 2'b11
    } lane_acc_e;

    function automatic cyc_t classify(input logic m_io, input logic rd_n, input logic wr_n);
        cyc_t c;
        c.mem = m_io;
        c.io  = ~m_io;
        c.rd  = ~rd_n;
        c.wr  = ~wr_n;
        return c;
    endfunction

    function automatic lane_acc_e lane_kind(input logic a0, input logic bhe_n);
        return lane_acc_e'({~bhe_n, ~a0});
    endfunction

endpackage

// File: rtl/busdec_region.sv
`timescale 1ns/1ps
module busdec_region #(
    parameter int          ADDR_W    = 20,
    parameter int          BANK_AW   = 13,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter bit          PARTIAL   = 1'b0,
    parameter int          PART_BITS = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // full decode compares everything above the bank lines and the lane bit
    localparam int FULL_BITS = ADDR_W - BANK_AW - 1;

    generate
        if (PARTIAL) begin : g_partial
            localparam logic [ADDR_W-1:0] PMASK = {ADDR_W{1'b1}} << (ADDR_W - PART_BITS);
            assign hit = ~|((addr ^ BASE) & PMASK);
        end else begin : g_full
            localparam logic [ADDR_W-1:0] FMASK = {ADDR_W{1'b1}} << (ADDR_W - FULL_BITS);
            assign hit = ~|((addr ^ BASE) & FMASK);
        end
    endgenerate
endmodule

// File: rtl/busdec_prio.sv
`timescale 1ns/1ps
module busdec_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/busdec_lanes.sv
`timescale 1ns/1ps
module busdec_lanes
    import busdec_pkg::*;
(
    input  logic a0,
    input  logic bhe_n,
    input  logic active,
    output logic even_en_n,
    output logic odd_en_n
);
    lane_acc_e kind;

    always_comb begin
        kind      = lane_kind(a0, bhe_n);
        even_en_n = 1'b1;
        odd_en_n  = 1'b1;
        if (active) begin
            unique case (kind)
                ACC_WORD: begin even_en_n = 1'b0; odd_en_n = 1'b0; end
                ACC_EVEN: even_en_n = 1'b0;
                ACC_ODD:  odd_en_n  = 1'b0;
                ACC_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/busdec_ioport.sv
`timescale 1ns/1ps
module busdec_ioport
    import busdec_pkg::*;
#(
    parameter int              IO_AW    = 16,
    parameter logic [IO_AW-1:0] PORT    = '0,
    parameter bit              IS_INPUT = 1'b1
) (
    input  logic [IO_AW-1:0] io_addr,
    input  cyc_t             cyc,
    output logic             rd_sel_n,
    output logic             wr_sel_n
);
    logic match;
    assign match = cyc.io && (io_addr == PORT);

    generate
        if (IS_INPUT) begin : g_in
            assign rd_sel_n = ~(match & cyc.rd);
            assign wr_sel_n = 1'b1;
        end else begin : g_out
            assign rd_sel_n = 1'b1;
            assign wr_sel_n = ~(match & cyc.wr);
        end
    endgenerate
endmodule

// File: rtl/sysbus_select.sv
`timescale 1ns/1ps
module sysbus_select
    import busdec_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BANK_AW = 13,
    parameter int IO_AW   = 16,
    parameter int NREG    = 3,
    parameter int NPORT   = 4,
    parameter logic [NREG*ADDR_W-1:0] REG_BASE = {20'h00000, 20'h04000, 20'hFC000},
    parameter logic [NREG-1:0]        REG_PARTIAL = 3'b100,
    parameter logic [NREG*8-1:0]      REG_PART_BITS = {8'd1, 8'd0, 8'd0},
    parameter logic [NPORT*IO_AW-1:0] PORT_ADDR = {16'h1F02, 16'h1F00, 16'h0042, 16'h0040},
    parameter logic [NPORT-1:0]       PORT_IS_IN = 4'b0101
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              m_io,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [NREG-1:0]   mem_cs_n,
    output logic              even_en_n,
    output logic              odd_en_n,
    output logic [NPORT-1:0]  io_rd_n,
    output logic [NPORT-1:0]  io_wr_n
);
    cyc_t            cyc;
    logic            mem_active;
    logic [NREG-1:0] hit;
    logic [NREG-1:0] gnt;
    logic            any_sel;

    assign cyc        = classify(m_io, rd_n, wr_n);
    assign mem_active = cyc.mem & (cyc.rd | cyc.wr);

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            busdec_region #(
                .ADDR_W   (ADDR_W),
                .BANK_AW  (BANK_AW),
                .BASE     (REG_BASE[i*ADDR_W +: ADDR_W]),
                .PARTIAL  (REG_PARTIAL[i]),
                .PART_BITS(int'(REG_PART_BITS[i*8 +: 8]))
            ) u_region (
                .addr(addr),
                .hit (hit[i])
            );
        end
    endgenerate

    busdec_prio #(.N(NREG)) u_prio (
        .req(hit),
        .gnt(gnt)
    );

    assign mem_cs_n = ~(gnt & {NREG{mem_active}});
    assign any_sel  = mem_active & (|gnt);

    busdec_lanes u_lanes (
        .a0       (addr[0]),
        .bhe_n    (bhe_n),
        .active   (any_sel),
        .even_en_n(even_en_n),
        .odd_en_n (odd_en_n)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            busdec_ioport #(
                .IO_AW   (IO_AW),
                .PORT    (PORT_ADDR[p*IO_AW +: IO_AW]),
                .IS_INPUT(PORT_IS_IN[p])
            ) u_port (
                .io_addr (addr[IO_AW-1:0]),
                .cyc     (cyc),
                .rd_sel_n(io_rd_n[p]),
                .wr_sel_n(io_wr_n[p])
            );
        end
    endgenerate
endmodule

// File: rtl/busdec_chk.sv
`timescale 1ns/1ps
module busdec_chk #(
    parameter int ADDR_W = 20,
    parameter int NREG   = 3,
    parameter int NPORT  = 4
) (
    input logic [ADDR_W-1:0] addr,
    input logic              bhe_n,
    input logic              m_io,
    input logic              rd_n,
    input logic              wr_n,
    input logic [NREG-1:0]   mem_cs_n,
    input logic              even_en_n,
    input logic              odd_en_n,
    input logic [NPORT-1:0]  io_rd_n,
    input logic [NPORT-1:0]  io_wr_n
);
    logic known;
    assign known = !$isunknown({addr, bhe_n, m_io, rd_n, wr_n, mem_cs_n,
                                even_en_n, odd_en_n, io_rd_n, io_wr_n});

    always_comb begin
        if (known) begin
            assert_one_cs_R3: assert ($countones(~mem_cs_n) <= 1)
                else $error("more than one region select low");
            assert_mem_in_io_R5: assert (m_io || (&mem_cs_n && even_en_n && odd_en_n))
                else $error("memory output active in I/O cycle");
            assert_quiet_R9: assert (!(rd_n && wr_n) ||
                                     (&mem_cs_n && even_en_n && odd_en_n && &io_rd_n && &io_wr_n))
                else $error("output active with no strobe");
            assert_even_lane_R4: assert (even_en_n || (!addr[0] && !(&mem_cs_n)))
                else $error("even lane enabled without A0 low and a region");
            assert_odd_lane_R4: assert (odd_en_n || (!bhe_n && !(&mem_cs_n)))
                else $error("odd lane enabled without high-byte enable and a region");
            assert_io_rd_R7: assert (&io_rd_n || (!rd_n && !m_io))
                else $error("port read select outside I/O read");
            assert_io_wr_R8: assert (&io_wr_n || (!wr_n && !m_io))
                else $error("port write select outside I/O write");
            assert_io_one_R6: assert ($onehot0(~io_rd_n) && $onehot0(~io_wr_n))
                else $error("two ports selected at once");
        end
    end
endmodule

bind sysbus_select busdec_chk #(
    .ADDR_W(ADDR_W),
    .NREG  (NREG),
    .NPORT (NPORT)
) u_chk (
    .addr     (addr),
    .bhe_n    (bhe_n),
    .m_io     (m_io),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .mem_cs_n (mem_cs_n),
    .even_en_n(even_en_n),
    .odd_en_n (odd_en_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n)
);

// File: tb/sysbus_select_tb.sv
`timescale 1ns/1ps
module sysbus_select_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        m_io = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [2:0]  mem_cs_n;
    logic        even_en_n, odd_en_n;
    logic [3:0]  io_rd_n, io_wr_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sysbus_select u_dut (
        .addr(addr), .bhe_n(bhe_n), .m_io(m_io), .rd_n(rd_n), .wr_n(wr_n),
        .mem_cs_n(mem_cs_n), .even_en_n(even_en_n), .odd_en_n(odd_en_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
    );

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else     cycles <= cycles + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s addr=%05h bhe_n=%0b m_io=%0b rd_n=%0b wr_n=%0b actual=%0h expected=%0h",
                     tag, addr, bhe_n, m_io, rd_n, wr_n, act, exp);
        end
    endtask

    // Behavioural reference: address windows written as numeric ranges
    task automatic apply_and_check();
        int a;
        bit strobe, mem, rd, wr;
        int exp_cs, exp_even, exp_odd, exp_rd, exp_wr;
        a      = int'(addr);
        rd     = !rd_n;
        wr     = !wr_n;
        strobe = rd || wr;
        mem    = m_io && strobe;
        exp_cs = 7;
        if (mem) begin
            if (a >= 'hFC000)                    exp_cs = 7 & ~1; // R1 window
            else if (a >= 'h04000 && a < 'h08000) exp_cs = 7 & ~2; // R3 wins over alias
            else if (a < 'h80000)                exp_cs = 7 & ~4; // R2 alias
        end
        exp_even = (exp_cs != 7 && (a % 2) == 0) ? 0 : 1;
        exp_odd  = (exp_cs != 7 && !bhe_n) ? 0 : 1;
        exp_rd = 15;
        exp_wr = 15;
        if (!m_io) begin
            case (a % 65536)
                'h0040: if (rd) exp_rd = 15 - 1;
                'h1F00: if (rd) exp_rd = 15 - 4;
                'h0042: if (wr) exp_wr = 15 - 2;
                'h1F02: if (wr) exp_wr = 15 - 8;
                default: ;
            endcase
        end
        @(negedge clk);
        chk("R1 R2 R3 R5 R9 mem_cs_n", int'(mem_cs_n), exp_cs);
        chk("R4 R5 lanes", int'({odd_en_n, even_en_n}), exp_odd * 2 + exp_even);
        chk("R6 R7 io_rd_n", int'(io_rd_n), exp_rd);
        chk("R6 R8 io_wr_n", int'(io_wr_n), exp_wr);
    endtask

    initial begin
        int bases[$] = '{'hFC000, 'hFBFFF, 'hFFFFF, 'hFE000, 'h04000, 'h07FFE,
                         'h03FFE, 'h08000, 'h7C000, 'h00000, 'h3C122, 'h80000,
                         'h00040, 'hF0040, 'h00042, 'h01F00, 'h11F02, 'h00044};
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R9: idle bus, every select high
        @(negedge clk);
        chk("R9 idle mem_cs_n", int'(mem_cs_n), 7);
        chk("R9 idle lanes", int'({odd_en_n, even_en_n}), 3);
        chk("R9 idle io", int'({io_rd_n, io_wr_n}), 255);
        foreach (bases[k]) begin
            for (int a0 = 0; a0 < 2; a0++) begin
                for (int bh = 0; bh < 2; bh++) begin
                    for (int mi = 0; mi < 2; mi++) begin
                        for (int st = 0; st < 4; st++) begin
                            @(posedge clk);
                            #1;
                            addr  = 20'(bases[k] | a0);
                            bhe_n = bh[0];
                            m_io  = mi[0];
                            rd_n  = st[0];
                            wr_n  = st[1];
                            apply_and_check();
                        end
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule